// File: doc/BRIEF.md
# I2C Master Command Sequencer

This block is an I2C bus master that software steers one bus event at a time. A control register holds five one-shot command bits: start, repeated start, stop, receive one byte, and acknowledge. Setting a bit launches that event on the open-drain SCL and SDA outputs. The hardware clears the bit when the event completes. Writing a byte to the data register makes the block shift that byte out MSB first. It then samples the slave's answer on the ninth clock and keeps it as an acknowledge-status flag. After a received byte, an acknowledge command drives a stored acknowledge value onto SDA for one clock.

Every event ends with a one-cycle completion pulse. A busy output covers the whole period from command acceptance to that pulse. Command or data writes made while busy are dropped and never queued. While the block does not own the bus, a small bus monitor watches the traffic of other masters. It raises a pulse when the first byte after a start is the all-zero general call address and general call detection is enabled. The SCL period is set by a programmable divider.

Top module: `i2c_cmd_master`

## Requirements
- R1: After reset, busy is 0, both line-drive outputs are 0 (released), the control register reads 0x00, and the divider register (address 2) reads its default of 4.
- R2: Writing control bit 0 (start) while idle produces SDA falling while SCL is high. The bit reads back 1 while pending and 0 after the completion pulse. SCL is left held low.
- R3: Writing a byte to address 1 while idle transmits it MSB first on 8 SCL high phases and releases SDA on a ninth. Control bit 7 then reads 1 if the slave left SDA high (no acknowledge) on that ninth clock and 0 if it pulled SDA low.
- R4: Control bit 3 (receive) clocks in 8 bits with SDA released, MSB first. Reading address 1 afterwards returns the received byte.
- R5: Control bit 4 (acknowledge) drives one SCL clock during which SDA carries control bit 5: 0 gives low (ACK) and 1 gives released (NACK).
- R6: Control bit 1 (repeated start) releases SDA while SCL is low, releases SCL, then pulls SDA low while SCL is high, and finally holds SCL low.
- R7: Control bit 2 (stop) produces SDA rising while SCL is high and leaves both lines released.
- R8: While busy, a write to control bits 0 to 4 sets none of them, and a write to address 1 is dropped. Writes to bits 5 and 6 are always taken.
- R9: Apart from start, repeated start and stop events, the master changes SDA only while it holds SCL low.
- R10: With control bit 6 set and the bus owned by another master, a 0x00 first byte after a start gives one gcall_irq pulse. A nonzero byte, or bit 6 clear, gives none.
- R11: done is high for exactly one clock cycle at the end of each start, repeated start, stop, byte transfer or acknowledge.
- R12: When several command bits are written at once, only the lowest-numbered one is kept and executed (start first, acknowledge last).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 control, 1 transmit byte, 2 divider |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address: 0 control/status, 1 received byte, 2 divider |
| rd_data | output | 8 | Read data for rd_addr |
| scl_i | input | 1 | Sensed SCL line level |
| sda_i | input | 1 | Sensed SDA line level |
| scl_lo | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_lo | output | 1 | 1 pulls SDA low, 0 releases it |
| done | output | 1 | One-cycle pulse when an event completes |
| busy | output | 1 | A command or transfer is pending or running |
| gcall_irq | output | 1 | One-cycle pulse on a detected general call address |

## Verification
A bus-side monitor decodes start, stop, byte and ninth-bit events from the wired line levels and compares them against an expected queue. A slave model acknowledges or refuses written bytes and supplies the read bytes. Written bytes with and without a slave acknowledge separate the two status values. Two reads answered by ACK and by NACK separate the acknowledge values driven. Commands and data written during a transfer, and a multi-bit command write, show that only one event runs. Frames from a second master carrying 0x00 or 0x55, with detection on or off, separate the general call cases.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  localparam int CMD_W   = 5;
  localparam int C_START = 0;
  localparam int C_RSTRT = 1;
  localparam int C_STOP  = 2;
  localparam int C_RECV  = 3;
  localparam int C_ACK   = 4;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_DATA = 2'd1;
  localparam logic [1:0] A_DIV  = 2'd2;

  typedef enum logic [2:0] {PH_IDLE, PH_START, PH_RSTRT, PH_STOP, PH_BITS} phase_t;
  typedef enum logic [1:0] {K_WR, K_RD, K_ACK} kind_t;
endpackage

// File: rtl/i2cm_tick.sv
module i2cm_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_n;

  always_comb begin
    if (!run || cnt_q == '0) cnt_n = div;
    else                     cnt_n = cnt_q - 1'b1;
  end

  assign tick = run && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end
endmodule

// File: rtl/i2cm_gcall_mon.sv
module i2cm_gcall_mon (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  input  logic enable,
  output logic irq
);
  logic       scl_q, sda_q, armed_q, armed_n, irq_n;
  logic [2:0] cnt_q, cnt_n;
  logic [7:0] sh_q, sh_n;
  logic       st_det, sp_det, rise;

  assign st_det = scl_i && scl_q && sda_q && !sda_i;
  assign sp_det = scl_i && scl_q && !sda_q && sda_i;
  assign rise   = scl_i && !scl_q;

  always_comb begin
    armed_n = armed_q;
    cnt_n   = cnt_q;
    sh_n    = sh_q;
    irq_n   = 1'b0;
    if (st_det) begin
      armed_n = 1'b1;
      cnt_n   = '0;
    end else if (sp_det) begin
      armed_n = 1'b0;
    end else if (rise && armed_q) begin
      sh_n  = {sh_q[6:0], sda_i};
      cnt_n = cnt_q + 1'b1;
      if (cnt_q == 3'd7) begin
        armed_n = 1'b0;
        irq_n   = enable && (sh_n == 8'h00);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q   <= 1'b1;
      sda_q   <= 1'b1;
      armed_q <= 1'b0;
      cnt_q   <= '0;
      sh_q    <= '0;
      irq     <= 1'b0;
    end else begin
      scl_q   <= scl_i;
      sda_q   <= sda_i;
      armed_q <= armed_n;
      cnt_q   <= cnt_n;
      sh_q    <= sh_n;
      irq     <= irq_n;
    end
  end
endmodule

// File: rtl/i2cm_engine.sv
module i2cm_engine import i2cm_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             go_wr,
  input  logic [7:0]       wr_byte,
  input  logic [CMD_W-1:0] go_cmd,
  input  logic             ack_val,
  input  logic             sda_i,
  output logic             active,
  output logic             done,
  output logic             scl_lo,
  output logic             sda_lo,
  output logic             cond_phase,
  output logic             bus_own,
  output logic             ack_status,
  output logic [7:0]       rx_byte
);
  phase_t     ph_q, ph_n;
  kind_t      kd_q, kd_n;
  logic [1:0] qt_q, qt_n;
  logic [3:0] bn_q, bn_n, last_q, last_n;
  logic [8:0] tx_q, tx_n;
  logic [7:0] sp_q, sp_n, rx_n;
  logic       scl_n, sda_n, own_n, ack_n, fin;

  always_comb begin
    ph_n = ph_q;  kd_n = kd_q;  qt_n = qt_q;  bn_n = bn_q;  last_n = last_q;
    tx_n = tx_q;  sp_n = sp_q;  scl_n = scl_lo;  sda_n = sda_lo;
    own_n = bus_own;  ack_n = ack_status;  rx_n = rx_byte;  fin = 1'b0;
    if (ph_q == PH_IDLE) begin
      qt_n = '0;
      bn_n = '0;
      if (!done) begin
        if (go_wr) begin
          ph_n = PH_BITS; kd_n = K_WR; tx_n = {wr_byte, 1'b1}; last_n = 4'd8;
        end else if (go_cmd[C_START]) ph_n = PH_START;
        else if (go_cmd[C_RSTRT])     ph_n = PH_RSTRT;
        else if (go_cmd[C_STOP])      ph_n = PH_STOP;
        else if (go_cmd[C_RECV]) begin
          ph_n = PH_BITS; kd_n = K_RD; tx_n = '1; last_n = 4'd7;
        end else if (go_cmd[C_ACK]) begin
          ph_n = PH_BITS; kd_n = K_ACK; tx_n = {ack_val, 8'hFF}; last_n = 4'd0;
        end
      end
    end else if (tick) begin
      qt_n = qt_q + 1'b1;
      case (ph_q)
        PH_START: case (qt_q)
          2'd0: begin sda_n = 1'b0; scl_n = 1'b0; end
          2'd1: sda_n = 1'b1;
          2'd3: begin scl_n = 1'b1; fin = 1'b1; own_n = 1'b1; end
          default: ;
        endcase
        PH_RSTRT: case (qt_q)
          2'd0: sda_n = 1'b0;
          2'd1: scl_n = 1'b0;
          2'd2: sda_n = 1'b1;
          default: begin scl_n = 1'b1; fin = 1'b1; own_n = 1'b1; end
        endcase
        PH_STOP: case (qt_q)
          2'd0: sda_n = 1'b1;
          2'd1: scl_n = 1'b0;
          2'd2: sda_n = 1'b0;
          default: begin fin = 1'b1; own_n = 1'b0; end
        endcase
        default: case (qt_q)
          2'd0: sda_n = !tx_q[8];
          2'd1: scl_n = 1'b0;
          2'd2: sp_n = {sp_q[6:0], sda_i};
          default: begin
            scl_n = 1'b1;
            tx_n  = {tx_q[7:0], 1'b1};
            if (bn_q == last_q) begin
              fin = 1'b1;
              if (kd_q == K_WR) ack_n = sp_q[0];
              if (kd_q == K_RD) rx_n  = sp_q;
            end else begin
              bn_n = bn_q + 1'b1;
            end
          end
        endcase
      endcase
      if (fin) ph_n = PH_IDLE;
    end
  end

  assign active     = (ph_q != PH_IDLE);
  assign cond_phase = (ph_q == PH_START) || (ph_q == PH_RSTRT) || (ph_q == PH_STOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= PH_IDLE;  kd_q <= K_WR;  qt_q <= '0;  bn_q <= '0;  last_q <= '0;
      tx_q <= '1;  sp_q <= '0;  scl_lo <= 1'b0;  sda_lo <= 1'b0;  done <= 1'b0;
      bus_own <= 1'b0;  ack_status <= 1'b0;  rx_byte <= '0;
    end else begin
      ph_q <= ph_n;  kd_q <= kd_n;  qt_q <= qt_n;  bn_q <= bn_n;  last_q <= last_n;
      tx_q <= tx_n;  sp_q <= sp_n;  scl_lo <= scl_n;  sda_lo <= sda_n;  done <= fin;
      bus_own <= own_n;  ack_status <= ack_n;  rx_byte <= rx_n;
    end
  end
endmodule

// File: rtl/i2c_cmd_master.sv
module i2c_cmd_master import i2cm_pkg::*; #(
  parameter int DIV_W     = 8,
  parameter int DIV_RESET = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [1:0] rd_addr,
  output logic [7:0] rd_data,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_lo,
  output logic       sda_lo,
  output logic       done,
  output logic       busy,
  output logic       gcall_irq
);
  logic [1:0]       rs_q;
  logic             rst_n_s;
  logic [CMD_W-1:0] cmd_q, cmd_n, cmd_req;
  logic             ackv_q, ackv_n, gc_en_q, gc_en_n;
  logic [DIV_W-1:0] div_q, div_n;
  logic             active, tick, cond_phase, bus_own, ack_status, go_wr;
  logic [7:0]       rx_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_n_s = rs_q[1];

  assign busy    = active || (|cmd_q) || done;
  assign cmd_req = wr_data[CMD_W-1:0] & (~wr_data[CMD_W-1:0] + 1'b1);
  assign go_wr   = wr_en && (wr_addr == A_DATA) && !busy;

  always_comb begin
    cmd_n = cmd_q;  ackv_n = ackv_q;  gc_en_n = gc_en_q;  div_n = div_q;
    if (done) cmd_n = '0;
    if (wr_en && wr_addr == A_CTRL) begin
      ackv_n  = wr_data[5];
      gc_en_n = wr_data[6];
      if (!busy) cmd_n = cmd_req;
    end
    if (wr_en && wr_addr == A_DIV) div_n = wr_data[DIV_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      cmd_q <= '0;  ackv_q <= 1'b0;  gc_en_q <= 1'b0;  div_q <= DIV_W'(DIV_RESET);
    end else begin
      cmd_q <= cmd_n;  ackv_q <= ackv_n;  gc_en_q <= gc_en_n;  div_q <= div_n;
    end
  end

  always_comb begin
    case (rd_addr)
      A_CTRL:  rd_data = {ack_status, gc_en_q, ackv_q, cmd_q};
      A_DATA:  rd_data = rx_byte;
      A_DIV:   rd_data = 8'(div_q);
      default: rd_data = 8'h00;
    endcase
  end

  i2cm_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n_s), .run(active), .div(div_q), .tick(tick)
  );

  i2cm_engine u_eng (
    .clk(clk), .rst_n(rst_n_s), .tick(tick), .go_wr(go_wr), .wr_byte(wr_data),
    .go_cmd(cmd_q), .ack_val(ackv_q), .sda_i(sda_i), .active(active), .done(done),
    .scl_lo(scl_lo), .sda_lo(sda_lo), .cond_phase(cond_phase), .bus_own(bus_own),
    .ack_status(ack_status), .rx_byte(rx_byte)
  );

  i2cm_gcall_mon u_gcm (
    .clk(clk), .rst_n(rst_n_s), .scl_i(scl_i), .sda_i(sda_i),
    .enable(gc_en_q && !bus_own && !active), .irq(gcall_irq)
  );
endmodule

// File: rtl/i2cm_checker.sv
module i2cm_checker #(
  parameter int CW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [1:0]    wr_addr,
  input logic [CW-1:0] cmd,
  input logic          busy,
  input logic          done,
  input logic          scl_lo,
  input logic          sda_lo,
  input logic          cond_phase,
  input logic          bus_own,
  input logic          gc_en,
  input logic          gcall_irq
);
  AST_CMD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cmd)); // R12

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R11

  AST_NO_SPOOL: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en && wr_addr == 2'd0) |=> ((cmd & ~$past(cmd)) == '0)); // R8

  AST_SDA_UNDER_LOW_SCL: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_lo != $past(sda_lo)) && !$past(cond_phase) |-> $past(scl_lo)); // R9

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !bus_own) |-> (!scl_lo && !sda_lo)); // R7

  AST_GCALL_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    gcall_irq |-> $past(gc_en) && !bus_own); // R10
endmodule

bind i2c_cmd_master i2cm_checker #(.CW(i2cm_pkg::CMD_W)) u_chk (
  .clk(clk), .rst_n(rst_n_s), .wr_en(wr_en), .wr_addr(wr_addr), .cmd(cmd_q),
  .busy(busy), .done(done), .scl_lo(scl_lo), .sda_lo(sda_lo),
  .cond_phase(cond_phase), .bus_own(bus_own), .gc_en(gc_en_q), .gcall_irq(gcall_irq)
);

// File: tb/i2c_cmd_master_test.sv
`timescale 1ns/1ps
module i2c_cmd_master_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [7:0] wr_data = 8'h00;
  logic [1:0] rd_addr = 2'd0;
  logic [7:0] rd_data;
  logic       scl_lo, sda_lo, done, busy, gcall_irq;
  logic       om_scl_lo = 1'b0, om_sda_lo = 1'b0, sl_sda_lo = 1'b0;
  logic       scl_line, sda_line;

  int checks = 0, failures = 0, gc_cnt = 0;
  logic [11:0] exp_q[$];
  string       tag_q[$];

  logic       sl_mode = 1'b0, sl_ack = 1'b1;
  logic [7:0] sl_tx = 8'h00;
  logic       ps = 1'b1, pd = 1'b1;
  logic [7:0] msh = 8'h00;
  int         bc = 0;

  always #4 clk = ~clk;

  assign scl_line = !(scl_lo || om_scl_lo);
  assign sda_line = !(sda_lo || sl_sda_lo || om_sda_lo);

  i2c_cmd_master uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .scl_i(scl_line), .sda_i(sda_line),
    .scl_lo(scl_lo), .sda_lo(sda_lo), .done(done), .busy(busy), .gcall_irq(gcall_irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic expect_ev(input logic [3:0] k, input logic [7:0] v, input string tag);
    exp_q.push_back({k, v});
    tag_q.push_back(tag);
  endtask

  task automatic got(input logic [3:0] k, input logic [7:0] v);
    logic [11:0] e;
    string t;
    checks++;
    if (exp_q.size() == 0) begin
      failures++;
      $display("FAIL R9 unexpected bus event act=%0h exp=none", {k, v});
    end else begin
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      if (e !== {k, v}) begin
        failures++;
        $display("FAIL %s bus event act=%0h exp=%0h", t, {k, v}, e);
      end
    end
  endtask

  // monitor (kinds: 1 start, 2 stop, 3 byte, 4 ninth bit) and slave model
  always @(negedge clk) begin
    if (rst_n) begin
      if (scl_line && ps && pd && !sda_line) begin
        got(4'd1, 8'h00); bc = 0;
      end else if (scl_line && ps && !pd && sda_line) begin
        got(4'd2, 8'h00); bc = 0;
      end else if (scl_line && !ps) begin
        if (bc < 8) msh = {msh[6:0], sda_line};
        if (bc == 7) got(4'd3, msh);
        if (bc == 8) got(4'd4, {7'd0, sda_line});
        bc = (bc == 8) ? 0 : bc + 1;
      end
      ps = scl_line;
      pd = sda_line;
      if (!scl_line) begin
        if (sl_mode) sl_sda_lo = (bc < 8) ? !sl_tx[7 - bc] : 1'b0;
        else         sl_sda_lo = (bc == 8) && sl_ack;
      end
    end
  end

  always @(negedge clk) if (rst_n && gcall_irq) gc_cnt++;

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic wait_done(input string tag);
    int n = 0;
    while (!done && n < 5000) begin
      @(negedge clk);
      n++;
    end
    check({tag, " completion seen"}, 32'(n < 5000), 32'd1);
    @(negedge clk);
    check("R11 done lasts one cycle", 32'(done), 32'd0);
    check({tag, " busy cleared"}, 32'(busy), 32'd0);
  endtask

  task automatic om_frame(input logic [7:0] b);
    om_sda_lo = 1'b1; repeat (4) @(negedge clk);
    om_scl_lo = 1'b1; repeat (2) @(negedge clk);
    for (int i = 7; i >= -1; i--) begin
      om_sda_lo = (i >= 0) ? !b[i] : 1'b0;
      repeat (2) @(negedge clk);
      om_scl_lo = 1'b0; repeat (4) @(negedge clk);
      om_scl_lo = 1'b1; repeat (2) @(negedge clk);
    end
    om_sda_lo = 1'b1; repeat (2) @(negedge clk);
    om_scl_lo = 1'b0; repeat (4) @(negedge clk);
    om_sda_lo = 1'b0; repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 busy", 32'(busy), 32'd0);
    check("R1 scl released", 32'(scl_lo), 32'd0);
    check("R1 sda released", 32'(sda_lo), 32'd0);
    rd(2'd0, d); check("R1 control", 32'(d), 32'h00);
    rd(2'd2, d); check("R1 divider", 32'(d), 32'd4);
    wr(2'd2, 8'd1);

    // R2 start
    sl_mode = 1'b0; sl_ack = 1'b1;
    expect_ev(4'd1, 8'h00, "R2 start");
    wr(2'd0, 8'h01);
    rd(2'd0, d); check("R2 start bit pending", 32'(d[0]), 32'd1);
    wait_done("R2");
    rd(2'd0, d); check("R2 start bit self-cleared", 32'(d[0]), 32'd0);
    check("R2 scl held low", 32'(scl_line), 32'd0);

    // R3 write with ACK, R8 writes while busy
    expect_ev(4'd3, 8'hA4, "R3 byte A4");
    expect_ev(4'd4, 8'h00, "R3 slave ack");
    wr(2'd1, 8'hA4);
    wr(2'd1, 8'h11);
    wr(2'd0, 8'h04);
    rd(2'd0, d); check("R8 command not latched while busy", 32'(d[4:0]), 32'd0);
    wait_done("R3");
    rd(2'd0, d); check("R3 ack status after ACK", 32'(d[7]), 32'd0);
    repeat (40) @(negedge clk);
    check("R8 rejected stop did not run", 32'(scl_line), 32'd0);
    check("R8 busy stays low", 32'(busy), 32'd0);

    // R3 write with no ACK
    sl_ack = 1'b0;
    expect_ev(4'd3, 8'h3C, "R3 byte 3C");
    expect_ev(4'd4, 8'h01, "R3 slave nack");
    wr(2'd1, 8'h3C);
    wait_done("R3");
    rd(2'd0, d); check("R3 ack status after NACK", 32'(d[7]), 32'd1);

    // R6 repeated start then address byte
    expect_ev(4'd1, 8'h00, "R6 repeated start");
    wr(2'd0, 8'h02);
    wait_done("R6");
    sl_ack = 1'b1;
    expect_ev(4'd3, 8'h5B, "R3 byte 5B");
    expect_ev(4'd4, 8'h00, "R3 slave ack");
    wr(2'd1, 8'h5B);
    wait_done("R3");

    // R4 read, R5 ACK
    sl_ack = 1'b0; sl_mode = 1'b1; sl_tx = 8'hC9;
    expect_ev(4'd3, 8'hC9, "R4 read C9");
    wr(2'd0, 8'h08);
    wait_done("R4");
    rd(2'd1, d); check("R4 received byte C9", 32'(d), 32'hC9);
    sl_mode = 1'b0;
    expect_ev(4'd4, 8'h00, "R5 master ACK");
    wr(2'd0, 8'h10);
    wait_done("R5");

    // R4 read, R5 NACK
    sl_mode = 1'b1; sl_tx = 8'h36;
    expect_ev(4'd3, 8'h36, "R4 read 36");
    wr(2'd0, 8'h08);
    wait_done("R4");
    rd(2'd1, d); check("R4 received byte 36", 32'(d), 32'h36);
    sl_mode = 1'b0;
    expect_ev(4'd4, 8'h01, "R5 master NACK");
    wr(2'd0, 8'h30);
    wait_done("R5");
    rd(2'd0, d); check("R5 ack value readback", 32'(d[5]), 32'd1);

    // R7 stop
    expect_ev(4'd2, 8'h00, "R7 stop");
    wr(2'd0, 8'h04);
    wait_done("R7");
    check("R7 scl released", 32'(scl_line), 32'd1);
    check("R7 sda released", 32'(sda_line), 32'd1);

    // R12 priority among simultaneous commands
    expect_ev(4'd1, 8'h00, "R12 only start runs");
    wr(2'd0, 8'h05);
    rd(2'd0, d); check("R12 only start latched", 32'(d[4:0]), 32'h01);
    wait_done("R12");
    repeat (40) @(negedge clk);
    check("R12 stop part dropped", 32'(scl_line), 32'd0);
    expect_ev(4'd2, 8'h00, "R7 stop");
    wr(2'd0, 8'h04);
    wait_done("R7");

    // R10 general call from another master
    wr(2'd0, 8'h40);
    rd(2'd0, d); check("R8 gc enable taken when idle", 32'(d[6]), 32'd1);
    expect_ev(4'd1, 8'h00, "R10 other start");
    expect_ev(4'd3, 8'h00, "R10 byte 00");
    expect_ev(4'd4, 8'h01, "R10 no ack");
    expect_ev(4'd2, 8'h00, "R10 other stop");
    om_frame(8'h00);
    check("R10 general call flagged", 32'(gc_cnt), 32'd1);
    expect_ev(4'd1, 8'h00, "R10 other start");
    expect_ev(4'd3, 8'h55, "R10 byte 55");
    expect_ev(4'd4, 8'h01, "R10 no ack");
    expect_ev(4'd2, 8'h00, "R10 other stop");
    om_frame(8'h55);
    check("R10 nonzero address not flagged", 32'(gc_cnt), 32'd1);
    wr(2'd0, 8'h00);
    expect_ev(4'd1, 8'h00, "R10 other start");
    expect_ev(4'd3, 8'h00, "R10 byte 00");
    expect_ev(4'd4, 8'h01, "R10 no ack");
    expect_ev(4'd2, 8'h00, "R10 other stop");
    om_frame(8'h00);
    check("R10 disabled general call ignored", 32'(gc_cnt), 32'd1);

    repeat (20) @(negedge clk);
    check("R9 all expected bus events seen", 32'(exp_q.size()), 32'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule